// File: doc/BRIEF.md
# Dual-Mode Host Bus Register Interface

This block lets a microprocessor reach a register file through one of several bus styles. Three configuration pins set the style. The first picks the data width: a 16-bit bus, or an 8-bit bus on the low byte lane. The second picks the strobes: separate active-low read and write strobes, or one active-low data strobe with a read/not-write select. The third picks how the address arrives: on its own 8-bit address lines, or on the low data lines during an address-latch-enable phase. Accesses count only while the active-low chip select is low.

Every bus pin passes through a two-flop synchronizer into the internal clock domain. The block finds the start and the end of each access and issues exactly one write pulse and one read pulse toward the register file. During a read it drives read data and byte-lane output enables, so the surrounding pad logic can build a tri-state bus. A small demonstration bank sits behind the interface. It holds scratch words, an interrupt enable mask and a read-only view of the event inputs. The bank drives an active-low interrupt.

Top module: `hostbus_if`

## Requirements
- R1: After synchronous reset, both output enables are low, `bus_dout` is zero, `irq_n` is high, and every scratch word and the mask read back as zero.
- R2: When `cfg_byte_mode` is 0 (16-bit), address bit 0 is ignored. Bits 7:1 select a 16-bit word that is written and read whole on `bus_din`/`bus_dout`.
- R3: When `cfg_byte_mode` is 1 (8-bit), address bit 0 selects the byte lane (0 = bits 7:0, 1 = bits 15:8 of the word). Write data comes from `bus_din[7:0]`, read data appears on `bus_dout[7:0]`, and `bus_doe_hi` is never raised.
- R4: When `cfg_ds_style` is 0, `bus_rd_n` low marks a read. A write takes effect when `bus_wr_n` returns high.
- R5: When `cfg_ds_style` is 1, `bus_ds_n` low with `bus_rnw` high is a read, and `bus_ds_n` low with `bus_rnw` low is a write. The write takes effect on the rising edge of `bus_ds_n`.
- R6: When `cfg_mux_addr` is 1, the address follows `bus_din[7:0]` while `bus_ale` is high and holds the value seen at its falling edge. `bus_addr` is ignored in this mode.
- R7: With `bus_cs_n` high, no strobe activity writes a register or raises an output enable.
- R8: Each write access yields exactly one single-cycle `reg_wr` pulse, and each read access yields one `reg_rd` pulse.
- R9: `bus_doe_lo` is high only while chip select and a read are both active, after a three-clock latency in each direction. `bus_dout` is zero whenever `bus_doe_lo` is low.
- R10: The word map is as follows:
  - words 0 to 3 are scratch;
  - word 8 (byte address 0x10) is the interrupt mask;
  - word 9 (0x12) is the read-only event view.
  Any other word reads as zero and ignores writes.
- R11: `irq_n` is low, one clock after the inputs, while any `evt_src` bit is high whose mask bit is 1. It returns high once the source clears or its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_byte_mode | input | 1 | 0 = 16-bit bus, 1 = 8-bit bus |
| cfg_ds_style | input | 1 | 0 = read/write strobes, 1 = data strobe plus read/not-write |
| cfg_mux_addr | input | 1 | 1 = address taken from the low data lines under `bus_ale` |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low (strobe style 0) |
| bus_wr_n | input | 1 | Write strobe, active low (strobe style 0) |
| bus_ds_n | input | 1 | Data strobe, active low (strobe style 1) |
| bus_rnw | input | 1 | 1 = read, 0 = write (strobe style 1) |
| bus_ale | input | 1 | Address latch enable (multiplexed mode) |
| bus_addr | input | 8 | Address lines (non-multiplexed mode) |
| bus_din | input | 16 | Data lines seen from the pads |
| bus_dout | output | 16 | Read data toward the pads |
| bus_doe_lo | output | 1 | Output enable for data bits 7:0 |
| bus_doe_hi | output | 1 | Output enable for data bits 15:8 |
| evt_src | input | 16 | Interrupt event sources, level, clock-synchronous |
| irq_n | output | 1 | Interrupt, active low |
| reg_wr | output | 1 | Register write pulse |
| reg_rd | output | 1 | Register read pulse |
| reg_word | output | 7 | Word index of the last write |

## Verification
The embedded properties watch several rules on every clock:
- a write pulse never lasts more than one cycle;
- a write pulse follows only a selected access;
- the upper lane enable stays low in 8-bit mode;
- read data is zero and undriven outside a selected read;
- unmapped words return zero;
- the interrupt releases only once no unmasked source remains.

The bench scenarios are needed for the rest: correct data through each combination of width, strobe style and address multiplexing, byte-lane placement, address hold after the latch enable falls, and interrupt assertion after a mask write made over the bus itself.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int HBI_AW = 8;
  localparam int HBI_DW = 16;
  localparam int HBI_WW = HBI_AW - 1;
  localparam logic [HBI_WW-1:0] MASK_WORD = 7'd8;
  localparam logic [HBI_WW-1:0] STAT_WORD = 7'd9;

  typedef struct packed {
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic              ds_n;
    logic              rnw;
    logic              ale;
    logic              byte_mode;
    logic              ds_style;
    logic              mux;
    logic [HBI_AW-1:0] addr;
    logic [HBI_DW-1:0] din;
  } bus_samp_t;

  localparam bus_samp_t SAMP_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                      ds_n: 1'b1, rnw: 1'b1, ale: 1'b0,
                                      byte_mode: 1'b0, ds_style: 1'b0, mux: 1'b0,
                                      addr: '0, din: '0};
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync
  import hbi_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  bus_samp_t d,
  output bus_samp_t q
);
  bus_samp_t pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= SAMP_IDLE;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= SAMP_IDLE;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode
  import hbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_samp_t         s,
  output logic [HBI_AW-1:0] addr_lat,
  output logic              rd_act,
  output logic              wr_pulse,
  output logic [HBI_AW-1:0] waddr_q,
  output logic [HBI_DW-1:0] wdata_q
);
  logic wr_lvl, wr_act, wr_act_q;

  // Address capture: follows the source while open, holds otherwise
  always_ff @(posedge clk) begin
    if (rst)
      addr_lat <= '0;
    else if (!s.mux)
      addr_lat <= s.addr;
    else if (s.ale)
      addr_lat <= s.din[HBI_AW-1:0];
  end

  always_comb begin
    if (s.ds_style) begin
      rd_act = !s.cs_n && !s.ds_n && s.rnw;
      wr_lvl = !s.ds_n && !s.rnw;
    end else begin
      rd_act = !s.cs_n && !s.rd_n;
      wr_lvl = !s.wr_n;
    end
    wr_act = !s.cs_n && wr_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act) begin
        waddr_q <= addr_lat;
        wdata_q <= s.din;
      end
    end
  end

  // One pulse when the write strobe (or the selected access) ends
  assign wr_pulse = wr_act_q && !wr_act;

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse); // R8
  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> $past(!s.cs_n)); // R7
endmodule

// File: rtl/hbi_regbank.sv
module hbi_regbank
  import hbi_pkg::*;
#(
  parameter int NSCR = 4,
  parameter int NEVT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [HBI_WW-1:0] wr_word,
  input  logic              wr_lane,
  input  logic              wr_byte,
  input  logic [HBI_DW-1:0] wr_data,
  input  logic [HBI_WW-1:0] rd_word,
  output logic [HBI_DW-1:0] rd_data,
  input  logic [NEVT-1:0]   evt_src,
  output logic              irq_n
);
  logic [HBI_DW-1:0] scr [NSCR];
  logic [HBI_DW-1:0] mask_q;
  logic              rd_mapped;

  function automatic logic [HBI_DW-1:0] merge(input logic [HBI_DW-1:0] old,
                                              input logic [HBI_DW-1:0] d,
                                              input logic byte_m, input logic lane);
    logic [HBI_DW-1:0] r;
    r = old;
    if (!byte_m)   r = d;
    else if (lane) r[HBI_DW-1:HBI_DW/2] = d[HBI_DW/2-1:0];
    else           r[HBI_DW/2-1:0]      = d[HBI_DW/2-1:0];
    return r;
  endfunction

  for (genvar i = 0; i < NSCR; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scr[i] <= '0;
      else if (wr && wr_word == HBI_WW'(i))
        scr[i] <= merge(scr[i], wr_data, wr_byte, wr_lane);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (wr && wr_word == MASK_WORD)
      mask_q <= merge(mask_q, wr_data, wr_byte, wr_lane);
  end

  always_comb begin
    rd_data   = '0;
    rd_mapped = 1'b0;
    for (int i = 0; i < NSCR; i++) begin
      if (rd_word == HBI_WW'(i)) begin
        rd_data   = scr[i];
        rd_mapped = 1'b1;
      end
    end
    if (rd_word == MASK_WORD) begin
      rd_data   = mask_q;
      rd_mapped = 1'b1;
    end
    if (rd_word == STAT_WORD) begin
      rd_data   = HBI_DW'(evt_src);
      rd_mapped = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(evt_src & mask_q[NEVT-1:0]);
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_mapped |-> rd_data == '0); // R10
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(~|(evt_src & mask_q[NEVT-1:0]))); // R11
endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NSCR        = 4,
  parameter int NEVT        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_byte_mode,
  input  logic              cfg_ds_style,
  input  logic              cfg_mux_addr,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_ds_n,
  input  logic              bus_rnw,
  input  logic              bus_ale,
  input  logic [HBI_AW-1:0] bus_addr,
  input  logic [HBI_DW-1:0] bus_din,
  output logic [HBI_DW-1:0] bus_dout,
  output logic              bus_doe_lo,
  output logic              bus_doe_hi,
  input  logic [NEVT-1:0]   evt_src,
  output logic              irq_n,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [HBI_WW-1:0] reg_word
);
  localparam int HALF = HBI_DW / 2;

  bus_samp_t         raw, s;
  logic [HBI_AW-1:0] addr_lat, waddr_q;
  logic [HBI_DW-1:0] wdata_q, rword, rsel, wr_data_r;
  logic              rd_act, rd_act_q, wr_pulse, wr_lane_r, wr_byte_r;

  assign raw = '{cs_n: bus_cs_n, rd_n: bus_rd_n, wr_n: bus_wr_n, ds_n: bus_ds_n,
                 rnw: bus_rnw, ale: bus_ale, byte_mode: cfg_byte_mode,
                 ds_style: cfg_ds_style, mux: cfg_mux_addr,
                 addr: bus_addr, din: bus_din};

  hbi_sync #(.STAGES(SYNC_STAGES)) u_sync (.clk(clk), .rst(rst), .d(raw), .q(s));

  hbi_decode u_dec (
    .clk(clk), .rst(rst), .s(s), .addr_lat(addr_lat), .rd_act(rd_act),
    .wr_pulse(wr_pulse), .waddr_q(waddr_q), .wdata_q(wdata_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr    <= 1'b0;
      reg_word  <= '0;
      wr_lane_r <= 1'b0;
      wr_byte_r <= 1'b0;
      wr_data_r <= '0;
    end else begin
      reg_wr <= wr_pulse;
      if (wr_pulse) begin
        reg_word  <= waddr_q[HBI_AW-1:1];
        wr_lane_r <= waddr_q[0];
        wr_byte_r <= s.byte_mode;
        wr_data_r <= wdata_q;
      end
    end
  end

  hbi_regbank #(.NSCR(NSCR), .NEVT(NEVT)) u_bank (
    .clk(clk), .rst(rst), .wr(reg_wr), .wr_word(reg_word), .wr_lane(wr_lane_r),
    .wr_byte(wr_byte_r), .wr_data(wr_data_r), .rd_word(addr_lat[HBI_AW-1:1]),
    .rd_data(rword), .evt_src(evt_src), .irq_n(irq_n)
  );

  always_comb begin
    if (!s.byte_mode)     rsel = rword;
    else if (addr_lat[0]) rsel = {{HALF{1'b0}}, rword[HBI_DW-1:HALF]};
    else                  rsel = {{HALF{1'b0}}, rword[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q   <= 1'b0;
      reg_rd     <= 1'b0;
      bus_dout   <= '0;
      bus_doe_lo <= 1'b0;
      bus_doe_hi <= 1'b0;
    end else begin
      rd_act_q   <= rd_act;
      reg_rd     <= rd_act && !rd_act_q;
      bus_dout   <= rd_act ? rsel : '0;
      bus_doe_lo <= rd_act;
      bus_doe_hi <= rd_act && !s.byte_mode;
    end
  end

  AST_HI_QUIET_BYTE: assert property (@(posedge clk) disable iff (rst)
    $past(s.byte_mode) |-> !bus_doe_hi); // R3
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    bus_doe_lo |-> $past(!s.cs_n)); // R9
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_doe_lo |-> bus_dout == '0); // R9
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd); // R8
endmodule

// File: tb/sim_hostbus_if.sv
module sim_hostbus_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic cfg_byte_mode = 0, cfg_ds_style = 0, cfg_mux_addr = 0;
  logic bus_cs_n = 1, bus_rd_n = 1, bus_wr_n = 1, bus_ds_n = 1, bus_rnw = 1, bus_ale = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_din = 0;
  logic [15:0] bus_dout;
  logic bus_doe_lo, bus_doe_hi, irq_n, reg_wr, reg_rd;
  logic [15:0] evt_src = 0;
  logic [6:0]  reg_word;

  hostbus_if u0 (
    .clk(clk), .rst(rst), .cfg_byte_mode(cfg_byte_mode), .cfg_ds_style(cfg_ds_style),
    .cfg_mux_addr(cfg_mux_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw), .bus_ale(bus_ale),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe_lo(bus_doe_lo), .bus_doe_hi(bus_doe_hi), .evt_src(evt_src),
    .irq_n(irq_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word)
  );

  int checks = 0, errors = 0, wcount = 0, rcount = 0;
  logic [15:0] m_scr [4];
  logic [15:0] m_mask;

  always @(posedge clk) begin
    if (reg_wr) wcount++;
    if (reg_rd) rcount++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_read(input bit bm, input logic [7:0] a);
    logic [15:0] w;
    logic [6:0] wi;
    wi = a[7:1];
    if (wi < 7'd4)      w = m_scr[wi[1:0]];
    else if (wi == 7'd8) w = m_mask;
    else if (wi == 7'd9) w = evt_src;
    else                 w = 16'h0;
    if (!bm) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d,
                                        input bit bm, input bit lane);
    if (!bm) return d;
    return lane ? {d[7:0], o[7:0]} : {o[15:8], d[7:0]};
  endfunction

  task automatic model_write(input bit bm, input logic [7:0] a, input logic [15:0] d);
    logic [6:0] wi;
    wi = a[7:1];
    if (wi < 7'd4)       m_scr[wi[1:0]] = merge(m_scr[wi[1:0]], d, bm, a[0]);
    else if (wi == 7'd8) m_mask = merge(m_mask, d, bm, a[0]);
  endtask

  task automatic addr_phase(input bit bm, input bit ds, input bit mx, input logic [7:0] a);
    cfg_byte_mode = bm; cfg_ds_style = ds; cfg_mux_addr = mx;
    if (mx) begin
      bus_addr = ~a;  // must be ignored in multiplexed mode
      bus_din = {8'hEE, a}; bus_ale = 1; cyc(4);
      bus_ale = 0; cyc(1);
      bus_din = 16'hFFFF ^ {8'h0, a}; cyc(3);  // lines change after the latch closes
    end else begin
      bus_addr = a; cyc(4);
    end
  endtask

  task automatic do_write(input bit bm, input bit ds, input bit mx,
                          input logic [7:0] a, input logic [15:0] d, input string tag);
    int w0;
    addr_phase(bm, ds, mx, a);
    w0 = wcount;
    bus_din = d; bus_cs_n = 0;
    if (ds) begin bus_rnw = 0; bus_ds_n = 0; end else bus_wr_n = 0;
    cyc(4);
    if (ds) bus_ds_n = 1; else bus_wr_n = 1;
    cyc(4);
    bus_cs_n = 1; bus_rnw = 1; cyc(4);
    model_write(bm, a, d);
    chk(wcount - w0 == 1, {tag, " R8 one write pulse"}, wcount - w0, 1);
  endtask

  task automatic do_read(input bit bm, input bit ds, input bit mx,
                         input logic [7:0] a, input string tag);
    logic [15:0] v, e;
    logic lo, hi;
    int r0;
    addr_phase(bm, ds, mx, a);
    r0 = rcount;
    bus_cs_n = 0;
    if (ds) begin bus_rnw = 1; bus_ds_n = 0; end else bus_rd_n = 0;
    cyc(5);
    v = bus_dout; lo = bus_doe_lo; hi = bus_doe_hi;
    if (ds) bus_ds_n = 1; else bus_rd_n = 1;
    bus_cs_n = 1; cyc(5);
    e = exp_read(bm, a);
    chk(v === e, {tag, " read data"}, v, e);
    chk(lo === 1'b1 && hi === !bm, {tag, " R9 R3 enables during read"}, {hi, lo}, {!bm, 1'b1});
    chk(bus_doe_lo === 1'b0 && bus_doe_hi === 1'b0 && bus_dout === 16'h0,
        {tag, " R9 released after read"}, {bus_doe_hi, bus_doe_lo, bus_dout}, 0);
    chk(rcount - r0 == 1, {tag, " R8 one read pulse"}, rcount - r0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 4; i++) m_scr[i] = 0;
    m_mask = 0;
    cyc(4); rst = 0; cyc(2);

    // R1 reset state
    chk(bus_doe_lo === 0 && bus_doe_hi === 0 && bus_dout === 0, "R1 enables/data after reset",
        {bus_doe_hi, bus_doe_lo, bus_dout}, 0);
    chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
    do_read(0, 0, 0, 8'h00, "R1 scratch0");
    do_read(0, 0, 0, 8'h10, "R1 mask");

    // R2 / R4 16-bit, separate strobes, bit 0 ignored
    do_write(0, 0, 0, 8'h02, 16'hA5C3, "R4 write");
    do_read(0, 0, 0, 8'h03, "R2 odd addr");
    do_write(0, 0, 0, 8'h07, 16'h1234, "R2 odd write");
    do_read(0, 0, 0, 8'h06, "R2 word3");

    // R3 byte lanes
    do_write(1, 0, 0, 8'h04, 16'hFF11, "R3 lane0");
    do_write(1, 0, 0, 8'h05, 16'hFF22, "R3 lane1");
    do_read(0, 0, 0, 8'h04, "R3 whole word");
    do_read(1, 0, 0, 8'h05, "R3 upper lane");
    do_read(1, 0, 0, 8'h04, "R3 lower lane");

    // R5 data strobe style
    do_write(0, 1, 0, 8'h00, 16'hBEEF, "R5 write");
    do_read(0, 1, 0, 8'h00, "R5 read");

    // R6 multiplexed address
    do_write(0, 0, 1, 8'h06, 16'h5A5A, "R6 write");
    do_read(0, 1, 1, 8'h06, "R6 read");

    // R7 strobes without chip select
    w0 = wcount;
    cfg_mux_addr = 0; cfg_ds_style = 0; cfg_byte_mode = 0;
    bus_addr = 8'h00; bus_din = 16'h0BAD; cyc(4);
    bus_wr_n = 0; cyc(4); bus_wr_n = 1; cyc(4);
    chk(wcount == w0, "R7 no write pulse without cs", wcount - w0, 0);
    bus_rd_n = 0; cyc(5);
    chk(bus_doe_lo === 0 && bus_doe_hi === 0, "R7 no drive without cs", {bus_doe_hi, bus_doe_lo}, 0);
    bus_rd_n = 1; cyc(4);
    do_read(0, 0, 0, 8'h00, "R7 data kept");

    // R10 unmapped
    do_write(0, 0, 0, 8'h20, 16'hCAFE, "R10 unmapped write");
    do_read(0, 0, 0, 8'h20, "R10 unmapped read");
    do_write(0, 0, 0, 8'h12, 16'hCAFE, "R10 status write");
    do_read(0, 0, 0, 8'h12, "R10 status read");

    // R11 interrupt
    evt_src = 16'h0004; cyc(3);
    chk(irq_n === 1'b1, "R11 masked source", irq_n, 1);
    do_read(0, 0, 0, 8'h12, "R11 event view");
    do_write(0, 0, 0, 8'h10, 16'h0004, "R11 mask on");
    chk(irq_n === 1'b0, "R11 unmasked source", irq_n, 0);
    evt_src = 16'h0000; cyc(3);
    chk(irq_n === 1'b1, "R11 source cleared", irq_n, 1);
    evt_src = 16'h0004; cyc(3);
    chk(irq_n === 1'b0, "R11 source again", irq_n, 0);
    do_write(1, 0, 0, 8'h10, 16'h0000, "R11 mask off");
    chk(irq_n === 1'b1, "R11 masked off", irq_n, 1);
    evt_src = 16'h0000;

    // random mix of modes and addresses
    for (int i = 0; i < 80; i++) begin
      bit bm, ds, mx, wr;
      logic [7:0] a;
      logic [15:0] d;
      bm = 1'($urandom); ds = 1'($urandom); mx = 1'($urandom); wr = 1'($urandom);
      case ($urandom % 4)
        0, 1: a = 8'($urandom % 8);
        2:    a = 8'h10 + 8'($urandom % 4);
        default: a = 8'($urandom);
      endcase
      d = 16'($urandom);
      if (wr) do_write(bm, ds, mx, a, d, "R2 R3 R4 R5 R6 random");
      else    do_read(bm, ds, mx, a, "R2 R3 R4 R5 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule